// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of a parallel 8-bit NAND flash bus and programs one page per request. A request gives a start column, a page address, a byte count and a choice of completion mode. The sequencer then takes over the bus. It selects the chip and writes the data-load command (0x80). It sends the three address cycles and streams the requested number of bytes from a valid/ready source. It writes the confirm command (0x10) to start programming.

The block then waits for the device to finish. It can watch the ready/busy pin, or it can issue the status command (0x70) and read the status byte until the ready bit is set. The pass/fail bit of the final status byte comes back with a one-cycle done pulse. If the device stays busy past a programmable limit, the request ends with a timeout flag.

Every write strobe and read strobe has its low and high widths set in clock cycles by parameters. Partial pages are supported: a load may start at any column and carry fewer bytes than the page holds.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle, nand_ale, nand_io_oe and done are 0, and req_ready is 1.
- R2: An accepted request with a nonzero length first writes 0x80 with CLE=1 and ALE=0. It then makes exactly three writes with ALE=1 and CLE=0, carrying in order: the column byte, page bits [7:0], and page bits [14:8] zero-extended to 8 bits.
- R3: After the address, the block makes exactly N writes with CLE=ALE=0, where N is the effective length. Their bytes are the stream bytes accepted through wr_valid/wr_ready, in the order accepted.
- R4: The write right after the last data byte is 0x10 with CLE=1.
- R5: Every write strobe has nand_we_n low for exactly T_WE_LOW clocks. During the clock before each falling edge, CLE, ALE and nand_io_out already hold the values they keep through the pulse, and nand_io_oe is 1.
- R6: In pin mode (req_poll=0), no status command is written before the block sees nand_rb high. After that it writes one 0x70 and does one status read. Bit 0 of that read drives fail (1 = fail).
- R7: In polling mode (req_poll=1), the block writes one 0x70 after the busy guard. It then repeats status reads until bit 6 reads 1, and bit 0 of that read drives fail.
- R8: Between the confirm command and done, the only command written is 0x70.
- R9: If the device is still busy BUSY_LIMIT clocks after the confirm command, the request ends with done=1, timeout_err=1 and fail=1.
- R10: A request with length 0 causes no bus activity (nand_ce_n stays 1) and ends with done=1 and fail=1.
- R11: done is a single-cycle pulse, and req_ready stays 0 from acceptance until done.
- R12: Every read strobe has nand_re_n low for exactly T_RE_LOW clocks, with nand_io_oe=0. nand_we_n and nand_re_n are never low together.
- R13: A length greater than PAGE_BYTES is treated as PAGE_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_col | input | 8 | Start column within the page |
| req_page | input | PAGE_W | Page address |
| req_len | input | LEN_W | Number of data bytes to load |
| req_poll | input | 1 | 1 = poll status, 0 = watch ready/busy pin |
| wr_data | input | 8 | Data byte |
| wr_valid | input | 1 | Data byte available |
| wr_ready | output | 1 | Sequencer takes the byte this cycle |
| done | output | 1 | One-cycle end-of-request pulse |
| fail | output | 1 | Program failed or timed out; valid with done |
| timeout_err | output | 1 | Device stayed busy past the limit; valid with done |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus data driven to the device |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Bus data from the device |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The bench uses short strobes: write low 2, write high 1, read low 2, read high 1. The busy guard is 2 clocks and the busy limit is 300. Both timeout paths can therefore be reached within a few hundred cycles, and every pulse width can be compared against a small exact count. PAGE_BYTES keeps its default of 528 and the length field is 10 bits wide. This makes room for a full-page load and for an oversize request that exercises clamping. Pin and polling modes are tested with random busy times and random injected fail bits.

// File: rtl/nand_seq_pkg.sv
// Shared types and constants for the NAND page program sequencer.
// Assumes an 8-bit device bus with status ready at bit 6 and fail at bit 0.
package nand_seq_pkg;

    // kind of one bus cycle carried out by the strobe engine
    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_DATA = 2'd2,
        OP_READ = 2'd3
    } bus_op_e;

    // sequencer control states
    typedef enum logic [3:0] {
        CS_IDLE     = 4'd0,
        CS_LOAD_CMD = 4'd1,
        CS_ADDR0    = 4'd2,
        CS_ADDR1    = 4'd3,
        CS_ADDR2    = 4'd4,
        CS_DATA     = 4'd5,
        CS_CONFIRM  = 4'd6,
        CS_GUARD    = 4'd7,
        CS_WAIT_RB  = 4'd8,
        CS_STAT_CMD = 4'd9,
        CS_STAT_RD  = 4'd10,
        CS_DONE     = 4'd11
    } ctrl_state_e;

    localparam logic [7:0] CMD_DATA_LOAD = 8'h80;
    localparam logic [7:0] CMD_CONFIRM   = 8'h10;
    localparam logic [7:0] CMD_STATUS    = 8'h70;
    localparam int         STAT_RDY_BIT  = 6;
    localparam int         STAT_FAIL_BIT = 0;

endpackage

// File: rtl/nand_bus_engine.sv
// Strobe engine: carries out one command, address, data-write or status-read
// bus cycle at a time. Phases: one setup clock with CLE/ALE/data set up,
// a low phase of the strobe, then a high recovery phase.
// Assumes all timing parameters are at least 1.
module nand_bus_engine
    import nand_seq_pkg::*;
#(
    parameter int T_WE_LOW  = 3,
    parameter int T_WE_HIGH = 2,
    parameter int T_RE_LOW  = 3,
    parameter int T_RE_HIGH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  bus_op_e    op,
    input  logic [7:0] wbyte,
    input  logic [7:0] io_in,
    output logic       idle,
    output logic       op_done,
    output logic [7:0] rd_byte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe
);

    localparam int MAX_W = (T_WE_LOW > T_WE_HIGH) ? T_WE_LOW : T_WE_HIGH;
    localparam int MAX_R = (T_RE_LOW > T_RE_HIGH) ? T_RE_LOW : T_RE_HIGH;
    localparam int MAX_T = (MAX_W > MAX_R) ? MAX_W : MAX_R;
    localparam int CW    = (MAX_T > 1) ? $clog2(MAX_T) : 1;
    localparam logic [CW-1:0] WL_LAST = CW'(T_WE_LOW - 1);
    localparam logic [CW-1:0] WH_LAST = CW'(T_WE_HIGH - 1);
    localparam logic [CW-1:0] RL_LAST = CW'(T_RE_LOW - 1);
    localparam logic [CW-1:0] RH_LAST = CW'(T_RE_HIGH - 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} phase_e;

    phase_e        phase;
    bus_op_e       op_q;
    logic [7:0]    byte_q;
    logic [7:0]    rd_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] low_last;
    logic [CW-1:0] high_last;
    logic          active;
    logic          is_read;

    // pick the phase lengths for the current cycle kind
    always_comb begin
        is_read   = (op_q == OP_READ);
        low_last  = is_read ? RL_LAST : WL_LAST;
        high_last = is_read ? RH_LAST : WH_LAST;
    end

    // phase sequencing, operand capture and status sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            op_q   <= OP_CMD;
            byte_q <= 8'h00;
            rd_q   <= 8'h00;
            cnt    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        op_q   <= op;
                        byte_q <= wbyte;
                        phase  <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    cnt   <= '0;
                    phase <= PH_LOW;
                end
                PH_LOW: begin
                    if (cnt == low_last) begin
                        cnt   <= '0;
                        phase <= PH_HIGH;
                        if (is_read) rd_q <= io_in;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == high_last) phase <= PH_IDLE;
                    else                  cnt   <= cnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // bus pins are decoded from registered phase and operand
    always_comb begin
        active  = (phase != PH_IDLE);
        idle    = !active;
        op_done = (phase == PH_HIGH) && (cnt == high_last);
        cle     = active && (op_q == OP_CMD);
        ale     = active && (op_q == OP_ADDR);
        io_oe   = active && !is_read;
        io_out  = io_oe ? byte_q : 8'h00;
        we_n    = !((phase == PH_LOW) && !is_read);
        re_n    = !((phase == PH_LOW) && is_read);
        rd_byte = rd_q;
    end

    // R5
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> ($stable(cle) && $stable(ale) && $stable(io_out) && io_oe));

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R12
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);

endmodule

// File: rtl/nand_busy_timer.sv
// Busy timeout counter: counts clocks while run is set, saturates at LIMIT
// and raises expired; clr restarts it. Assumes LIMIT >= 1.
module nand_busy_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);

    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] cnt;

    // count busy clocks up to the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       cnt <= '0;
        else if (run && !expired) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);

    // R9
    expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> expired);

endmodule

// File: rtl/nand_prog_ctrl.sv
// Program sequence controller: accepts a request, drives the strobe engine
// through load command, three address cycles, data, confirm, busy wait and
// status read, then reports done/fail/timeout. Assumes PAGE_W <= 16 and the
// ready/busy pin is asynchronous (it is synchronised here).
module nand_prog_ctrl
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES   = 528,
    parameter int PAGE_W       = 15,
    parameter int LEN_W        = 10,
    parameter int T_BUSY_GUARD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_col,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_poll,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              done,
    output logic              fail,
    output logic              timeout_err,
    output logic              ce_n,
    input  logic              rb,
    input  logic              eng_idle,
    input  logic              eng_done,
    input  logic [7:0]        eng_rd,
    output logic              eng_start,
    output bus_op_e           eng_op,
    output logic [7:0]        eng_byte,
    input  logic              tmr_expired,
    output logic              tmr_clr,
    output logic              tmr_run
);

    localparam int GW = $clog2(T_BUSY_GUARD + 1);
    localparam logic [GW-1:0]    G_LAST  = GW'(T_BUSY_GUARD - 1);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(PAGE_BYTES);

    ctrl_state_e       st;
    logic [7:0]        col_q;
    logic [PAGE_W-1:0] page_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  sent;
    logic [LEN_W-1:0]  sent_nx;
    logic              poll_q;
    logic              launched;
    logic [GW-1:0]     guard_cnt;
    logic              fail_q;
    logic              tmo_q;
    logic              rb_s1, rb_s2;
    logic              op_state;
    logic              busy_phase;

    // bring the ready/busy pin into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_s1 <= 1'b0;
            rb_s2 <= 1'b0;
        end else begin
            rb_s1 <= rb;
            rb_s2 <= rb_s1;
        end
    end

    // select the bus cycle for the current state
    always_comb begin
        eng_op   = OP_CMD;
        eng_byte = 8'h00;
        op_state = 1'b1;
        case (st)
            CS_LOAD_CMD: begin eng_op = OP_CMD;  eng_byte = CMD_DATA_LOAD;        end
            CS_ADDR0:    begin eng_op = OP_ADDR; eng_byte = col_q;                end
            CS_ADDR1:    begin eng_op = OP_ADDR; eng_byte = page_q[7:0];          end
            CS_ADDR2:    begin eng_op = OP_ADDR; eng_byte = 8'(page_q >> 8);      end
            CS_DATA:     begin eng_op = OP_DATA; eng_byte = wr_data;              end
            CS_CONFIRM:  begin eng_op = OP_CMD;  eng_byte = CMD_CONFIRM;          end
            CS_STAT_CMD: begin eng_op = OP_CMD;  eng_byte = CMD_STATUS;           end
            CS_STAT_RD:  begin eng_op = OP_READ; eng_byte = 8'h00;                end
            default:     op_state = 1'b0;
        endcase
    end

    // handshakes and pin-level outputs
    always_comb begin
        sent_nx     = sent + LEN_W'(1);
        wr_ready    = (st == CS_DATA) && eng_idle && !launched;
        eng_start   = op_state && eng_idle && !launched && ((st != CS_DATA) || wr_valid);
        busy_phase  = (st == CS_GUARD) || (st == CS_WAIT_RB) ||
                      (st == CS_STAT_CMD) || (st == CS_STAT_RD);
        tmr_clr     = (st == CS_CONFIRM);
        tmr_run     = busy_phase;
        req_ready   = (st == CS_IDLE);
        done        = (st == CS_DONE);
        fail        = fail_q;
        timeout_err = tmo_q;
        ce_n        = (st == CS_IDLE) || (st == CS_DONE);
    end

    // one launch per bus cycle; cleared when the engine finishes it
    always_ff @(posedge clk) begin
        if (!rst_n)         launched <= 1'b0;
        else if (eng_start) launched <= 1'b1;
        else if (eng_done)  launched <= 1'b0;
    end

    // main sequence of the program operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= CS_IDLE;
            col_q     <= 8'h00;
            page_q    <= '0;
            len_q     <= '0;
            sent      <= '0;
            poll_q    <= 1'b0;
            guard_cnt <= '0;
            fail_q    <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            case (st)
                CS_IDLE: begin
                    if (req_valid) begin
                        col_q  <= req_col;
                        page_q <= req_page;
                        len_q  <= (req_len > LEN_MAX) ? LEN_MAX : req_len;
                        poll_q <= req_poll;
                        sent   <= '0;
                        tmo_q  <= 1'b0;
                        if (req_len == '0) begin
                            fail_q <= 1'b1;
                            st     <= CS_DONE;
                        end else begin
                            fail_q <= 1'b0;
                            st     <= CS_LOAD_CMD;
                        end
                    end
                end
                CS_LOAD_CMD: if (eng_done) st <= CS_ADDR0;
                CS_ADDR0:    if (eng_done) st <= CS_ADDR1;
                CS_ADDR1:    if (eng_done) st <= CS_ADDR2;
                CS_ADDR2:    if (eng_done) st <= CS_DATA;
                CS_DATA: begin
                    if (eng_done) begin
                        sent <= sent_nx;
                        if (sent_nx == len_q) st <= CS_CONFIRM;
                    end
                end
                CS_CONFIRM: begin
                    if (eng_done) begin
                        guard_cnt <= '0;
                        st        <= CS_GUARD;
                    end
                end
                CS_GUARD: begin
                    if (guard_cnt == G_LAST) st <= poll_q ? CS_STAT_CMD : CS_WAIT_RB;
                    else                     guard_cnt <= guard_cnt + 1'b1;
                end
                CS_WAIT_RB: begin
                    if (rb_s2) begin
                        st <= CS_STAT_CMD;
                    end else if (tmr_expired) begin
                        tmo_q  <= 1'b1;
                        fail_q <= 1'b1;
                        st     <= CS_DONE;
                    end
                end
                CS_STAT_CMD: if (eng_done) st <= CS_STAT_RD;
                CS_STAT_RD: begin
                    if (eng_done) begin
                        if (eng_rd[STAT_RDY_BIT]) begin
                            fail_q <= eng_rd[STAT_FAIL_BIT];
                            st     <= CS_DONE;
                        end else if (tmr_expired) begin
                            tmo_q  <= 1'b1;
                            fail_q <= 1'b1;
                            st     <= CS_DONE;
                        end
                    end
                end
                CS_DONE: st <= CS_IDLE;
                default: st <= CS_IDLE;
            endcase
        end
    end

    // R8
    busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_phase && eng_start && eng_op == OP_CMD) |-> (eng_byte == CMD_STATUS));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    // R9
    tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout_err) |-> fail);

    // R10
    zero_len_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_len == '0) |=> (done && ce_n));

endmodule

// File: rtl/nand_prog_seq.sv
// Top of the NAND page program sequencer: joins the controller, the strobe
// engine and the busy timeout counter. Assumes the host holds req_* stable
// while req_valid is set and req_ready is low.
module nand_prog_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES   = 528,
    parameter int PAGE_W       = 15,
    parameter int LEN_W        = $clog2(PAGE_BYTES + 1),
    parameter int T_WE_LOW     = 3,
    parameter int T_WE_HIGH    = 2,
    parameter int T_RE_LOW     = 3,
    parameter int T_RE_HIGH    = 2,
    parameter int T_BUSY_GUARD = 4,
    parameter int BUSY_LIMIT   = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_col,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_poll,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              done,
    output logic              fail,
    output logic              timeout_err,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic [7:0]        nand_io_in,
    input  logic              nand_rb
);

    logic       eng_idle, eng_done, eng_start;
    logic [7:0] eng_rd, eng_byte;
    bus_op_e    eng_op;
    logic       tmr_expired, tmr_clr, tmr_run;

    nand_prog_ctrl #(
        .PAGE_BYTES  (PAGE_BYTES),
        .PAGE_W      (PAGE_W),
        .LEN_W       (LEN_W),
        .T_BUSY_GUARD(T_BUSY_GUARD)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_col    (req_col),
        .req_page   (req_page),
        .req_len    (req_len),
        .req_poll   (req_poll),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .done       (done),
        .fail       (fail),
        .timeout_err(timeout_err),
        .ce_n       (nand_ce_n),
        .rb         (nand_rb),
        .eng_idle   (eng_idle),
        .eng_done   (eng_done),
        .eng_rd     (eng_rd),
        .eng_start  (eng_start),
        .eng_op     (eng_op),
        .eng_byte   (eng_byte),
        .tmr_expired(tmr_expired),
        .tmr_clr    (tmr_clr),
        .tmr_run    (tmr_run)
    );

    nand_bus_engine #(
        .T_WE_LOW (T_WE_LOW),
        .T_WE_HIGH(T_WE_HIGH),
        .T_RE_LOW (T_RE_LOW),
        .T_RE_HIGH(T_RE_HIGH)
    ) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .op     (eng_op),
        .wbyte  (eng_byte),
        .io_in  (nand_io_in),
        .idle   (eng_idle),
        .op_done(eng_done),
        .rd_byte(eng_rd),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .io_out (nand_io_out),
        .io_oe  (nand_io_oe)
    );

    nand_busy_timer #(
        .LIMIT(BUSY_LIMIT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .run    (tmr_run),
        .expired(tmr_expired)
    );

    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));

endmodule

// File: tb/nand_prog_seq_tb.sv
module nand_prog_seq_tb;

    localparam int PB   = 528;
    localparam int PW   = 15;
    localparam int LW   = 10;
    localparam int TWL  = 2;
    localparam int TWH  = 1;
    localparam int TRL  = 2;
    localparam int TRH  = 1;
    localparam int TG   = 2;
    localparam int TLIM = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [7:0] req_col = 8'h00;
    logic [PW-1:0] req_page = '0;
    logic [LW-1:0] req_len = '0;
    logic req_poll = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic done, fail, timeout_err;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0] nand_io_out;
    logic [7:0] nand_io_in;
    logic nand_rb = 1'b1;
    logic fail_inject = 1'b0;

    always #10 clk = ~clk;

    assign nand_io_in = {1'b0, nand_rb, 5'b00000, fail_inject};

    nand_prog_seq #(
        .PAGE_BYTES(PB), .PAGE_W(PW), .LEN_W(LW),
        .T_WE_LOW(TWL), .T_WE_HIGH(TWH), .T_RE_LOW(TRL), .T_RE_HIGH(TRH),
        .T_BUSY_GUARD(TG), .BUSY_LIMIT(TLIM)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_col(req_col), .req_page(req_page), .req_len(req_len), .req_poll(req_poll),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .done(done), .fail(fail), .timeout_err(timeout_err),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rb(nand_rb)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device model state and bus log
    logic [1:0] log_kind [0:1023];
    logic [7:0] log_byte [0:1023];
    logic       log_rb   [0:1023];
    int log_n = 0, rd_n = 0, ce_low_n = 0;
    int we_run = 0, re_run = 0, we_bad = 0, re_bad = 0, setup_bad = 0;
    int busy_left = 0, busy_len = 10;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_cle = 1'b0, prev_ale = 1'b0, prev_oe = 1'b0;
    logic [7:0] prev_io = 8'h00, cap_io = 8'h00;
    logic cap_cle = 1'b0, cap_ale = 1'b0;

    // bus monitor and busy model, sampled on the falling edge
    always @(negedge clk) begin
        if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) nand_rb = 1'b1;
        end
        if (!nand_ce_n) ce_low_n++;
        if (!nand_we_n) begin
            if (prev_we) begin
                we_run = 1;
                if (!(prev_cle == nand_cle && prev_ale == nand_ale &&
                      prev_io == nand_io_out && prev_oe)) setup_bad++;
            end else we_run++;
            cap_cle = nand_cle; cap_ale = nand_ale; cap_io = nand_io_out;
        end else if (!prev_we) begin
            if (we_run != TWL) we_bad++;
            if (log_n < 1024) begin
                log_kind[log_n] = (cap_cle && !cap_ale) ? 2'd0 :
                                  (cap_ale && !cap_cle) ? 2'd1 :
                                  (!cap_ale && !cap_cle) ? 2'd2 : 2'd3;
                log_byte[log_n] = cap_io;
                log_rb[log_n]   = nand_rb;
                log_n++;
            end
            if (cap_cle && cap_io == 8'h10) begin
                busy_left = busy_len;
                nand_rb   = 1'b0;
            end
        end
        if (!nand_re_n) begin
            re_run = prev_re ? 1 : re_run + 1;
            if (nand_io_oe || !nand_we_n) re_bad++;
        end else if (!prev_re) begin
            if (re_run != TRL) re_bad++;
            rd_n++;
        end
        prev_we = nand_we_n; prev_re = nand_re_n; prev_cle = nand_cle;
        prev_ale = nand_ale; prev_io = nand_io_out; prev_oe = nand_io_oe;
    end

    // data stream source
    logic [7:0] dat [0:1023];
    int feed_idx = 0, feed_len = 0;
    bit feed_on = 1'b0;
    logic hs = 1'b0;
    always @(posedge clk) hs <= wr_valid && wr_ready;
    always @(negedge clk) begin
        if (hs) feed_idx++;
        if (feed_on && feed_idx < feed_len && ($urandom % 4 != 0)) begin
            wr_valid = 1'b1;
            wr_data  = dat[feed_idx];
        end else begin
            wr_valid = 1'b0;
        end
    end

    task automatic run_txn(input logic [7:0] col, input logic [PW-1:0] page,
                           input int len, input bit poll, input int blen,
                           input bit finj, input bit exp_tmo);
        int eff;
        int base;
        int cyc;
        int rdy_bad;
        bit got_fail, got_tmo, seen_done;
        eff = (len > PB) ? PB : len;
        for (int i = 0; i < eff; i++) dat[i] = 8'($urandom);
        @(negedge clk);
        log_n = 0; rd_n = 0; ce_low_n = 0;
        busy_len = blen; fail_inject = finj;
        feed_idx = 0; feed_len = eff; feed_on = 1'b1;
        req_col = col; req_page = page; req_len = LW'(len); req_poll = poll;
        check(req_ready == 1'b1, "R11 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0; rdy_bad = 0; seen_done = 1'b0; got_fail = 1'b0; got_tmo = 1'b0;
        while (!seen_done && cyc < 20000) begin
            if (done) begin
                seen_done = 1'b1; got_fail = fail; got_tmo = timeout_err;
            end else begin
                if (req_ready) rdy_bad++;
                @(negedge clk);
                cyc++;
            end
        end
        @(negedge clk);
        check(seen_done && !done, "R11 done single pulse", int'(done), 0);
        check(rdy_bad == 0, "R11 ready low while running", rdy_bad, 0);
        feed_on = 1'b0;
        busy_left = 0; nand_rb = 1'b1;
        if (len == 0) begin
            // R10
            check(ce_low_n == 0 && log_n == 0, "R10 no bus activity", ce_low_n + log_n, 0);
            check(got_fail == 1'b1, "R10 fail on empty load", int'(got_fail), 1);
            return;
        end
        // R2 header
        check(log_n >= 4 && log_kind[0] == 2'd0 && log_byte[0] == 8'h80,
              "R2 load command", int'(log_byte[0]), 8'h80);
        check(log_kind[1] == 2'd1 && log_byte[1] == col, "R2 column cycle",
              int'(log_byte[1]), int'(col));
        check(log_kind[2] == 2'd1 && log_byte[2] == page[7:0], "R2 page low cycle",
              int'(log_byte[2]), int'(page[7:0]));
        check(log_kind[3] == 2'd1 && log_byte[3] == {1'b0, page[14:8]}, "R2 page high cycle",
              int'(log_byte[3]), int'({1'b0, page[14:8]}));
        // R3 data, R13 clamp
        begin
            int miss = 0;
            for (int i = 0; i < eff; i++)
                if (log_kind[4+i] != 2'd2 || log_byte[4+i] != dat[i]) miss++;
            check(miss == 0, (len > PB) ? "R13 clamped data bytes" : "R3 data bytes", miss, 0);
        end
        base = 4 + eff;
        check(log_kind[base] == 2'd0 && log_byte[base] == 8'h10, "R4 confirm command",
              int'(log_byte[base]), 8'h10);
        // R8 / R6 / R7 status phase
        if (exp_tmo && !poll) begin
            check(log_n == base + 1 && rd_n == 0, "R6 no status while busy", log_n, base + 1);
        end else begin
            check(log_n == base + 2 && log_kind[base+1] == 2'd0 && log_byte[base+1] == 8'h70,
                  "R8 only status command after confirm", log_n, base + 2);
            if (!poll) begin
                check(rd_n == 1 && log_rb[base+1] == 1'b1, "R6 one read after ready pin", rd_n, 1);
            end else begin
                check(rd_n >= 1, "R7 status polled", rd_n, 1);
            end
        end
        if (exp_tmo) begin
            check(got_tmo && got_fail, "R9 timeout flagged with fail",
                  int'({got_tmo, got_fail}), 3);
        end else begin
            check(!got_tmo && got_fail == finj, poll ? "R7 fail bit" : "R6 fail bit",
                  int'(got_fail), int'(finj));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe
              && !done && req_ready, "R1 reset outputs",
              int'({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe, done, req_ready}),
              8'b1110_0001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed corners
        run_txn(8'h00, 15'h7FFF, 1, 1'b0, 12, 1'b0, 1'b0);
        run_txn(8'hFF, 15'h4A5C, 3, 1'b1, 40, 1'b1, 1'b0);
        run_txn(8'h10, 15'h0123, 0, 1'b0, 10, 1'b0, 1'b0);
        run_txn(8'h00, 15'h2000, PB, 1'b1, 30, 1'b0, 1'b0);
        run_txn(8'h20, 15'h1111, 1000, 1'b0, 20, 1'b1, 1'b0);
        run_txn(8'h44, 15'h0F0F, 5, 1'b0, 5000, 1'b0, 1'b1);
        run_txn(8'h45, 15'h7070, 4, 1'b1, 5000, 1'b0, 1'b1);
        // random mix
        for (int k = 0; k < 14; k++) begin
            run_txn(8'($urandom), PW'($urandom), 1 + int'($urandom % 40), 1'($urandom),
                    5 + int'($urandom % 120), 1'($urandom), 1'b0);
        end
        // strobe timing accumulated over the run
        check(we_bad == 0, "R5 write low width", we_bad, 0);
        check(setup_bad == 0, "R5 setup before write strobe", setup_bad, 0);
        check(re_bad == 0, "R12 read strobe width and drive", re_bad, 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule